// File: doc/BRIEF.md
# Transmit Audio Interrupt Status Unit

This block sits beside the transmit FIFO of an audio serial link and turns the FIFO's live status into interrupt sources. It keeps a sticky underrun flag, which is set when the drain logic empties the FIFO and cleared only by a host write. It also holds a raw interrupt status vector, a host-written enable mask and one masked interrupt line.

The raw bits follow their sources as levels rather than being latched. Only the underrun source can be cleared by software. The raw vector, the mask and the line are all registered and update together on the clock edge that samples a status change or a host write. A summary read value gives the raw vector zero-extended to the host data width.

Host writes use one select bit. Select 0 writes the enable mask. Select 1 writes the interrupt-clear register.

Top module: `audio_irq_unit`

## Requirements
- R1: After reset, `irq` is 0, `raw_status` is 0, `underrun` is 0 and the enable mask is 0.
- R2: A cycle with `tx_underrun_set` high makes `underrun` 1 after that edge. The flag then holds until it is cleared.
- R3: A host write with `host_sel`=1 and bit CLR_BIT of `host_wdata` set clears `underrun` at that edge. Such a write with that bit at 0 leaves the flag unchanged. If `tx_underrun_set` is high in the same cycle, the set wins.
- R4: `raw_status` bit 0 equals the underrun flag value that holds after the same edge.
- R5: `raw_status` bit 1 equals `tx_half_empty` as sampled at the previous edge.
- R6: `raw_status` bit 2 is 1 exactly when `tx_busy` was 0 and `tx_empty` was 1 at the previous edge.
- R7: `raw_status` bits 6 down to 3 are always 0.
- R8: A host write with `host_sel`=0 loads bits 6:0 of `host_wdata` into the enable mask. A mask bit of 1 enables the raw bit in the same position.
- R9: `irq` is 1 exactly when the registered raw vector ANDed with the registered mask is non-zero. It changes on the same edge as the raw vector, one cycle after the status input changes.
- R10: `summary_rd` equals `raw_status` zero-extended to DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_underrun_set | input | 1 | Pulse from the drain logic when the FIFO runs empty |
| tx_half_empty | input | 1 | FIFO level is at or below half |
| tx_empty | input | 1 | FIFO holds no samples |
| tx_busy | input | 1 | Transmitter is shifting a frame |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 selects the enable mask, 1 selects the clear register |
| host_wdata | input | DATA_W | Host write data |
| underrun | output | 1 | Sticky underrun status flag |
| raw_status | output | 7 | Registered raw interrupt vector |
| summary_rd | output | DATA_W | Summary read value of all interrupt bits |
| irq | output | 1 | Registered masked interrupt line |

## Verification
The bench builds the block with DATA_W=16 and CLR_BIT=2, so the clear bit sits away from bit 0. With that setting, a clear write that carries only bit 0 must leave the flag set, and the summary must show zeros above bit 6 within a narrower word. Random traffic mixes status levels, underrun pulses and both write targets. Directed cases cover a set and a clear in the same cycle, a clear write with the clear bit off, and a mask of all ones followed by a mask of zero.

// File: rtl/aiu_pkg.sv
package aiu_pkg;
  localparam int RAW_W   = 7;
  localparam int UR_POS  = 0;
  localparam int TX_POS  = 1;
  localparam int TXC_POS = 2;

  function automatic logic [RAW_W-1:0] derive_raw(input logic ur, input logic half,
                                                  input logic empty, input logic busy);
    logic [RAW_W-1:0] r;
    r          = '0;
    r[UR_POS]  = ur;
    r[TX_POS]  = half;
    r[TXC_POS] = empty & ~busy;
    return r;
  endfunction
endpackage

// File: rtl/aiu_underrun_flag.sv
module aiu_underrun_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_d,
  output logic flag_q
);
  always_comb begin
    if (set_evt)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;

  // R2
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R3
  underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);
  // R2
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(flag_q));
endmodule

// File: rtl/aiu_mask_reg.sv
module aiu_mask_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  assign mask_d = wr ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mask_q == $past(wdata));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q));
endmodule

// File: rtl/aiu_raw_line.sv
module aiu_raw_line
  import aiu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ur_next,
  input  logic             half,
  input  logic             empty,
  input  logic             busy,
  input  logic [RAW_W-1:0] mask_next,
  input  logic [RAW_W-1:0] mask_now,
  output logic [RAW_W-1:0] raw_q,
  output logic             irq_q
);
  logic [RAW_W-1:0] raw_d;
  logic             irq_d;
  logic             running_q;

  assign raw_d = derive_raw(ur_next, half, empty, busy);
  assign irq_d = |(raw_d & mask_next);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw_q     <= '0;
      irq_q     <= 1'b0;
      running_q <= 1'b0;
    end else begin
      raw_q     <= raw_d;
      irq_q     <= irq_d;
      running_q <= 1'b1;
    end

  // R5
  tx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> raw_q[TX_POS] == $past(half));
  // R6
  txc_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> raw_q[TXC_POS] == $past(empty && !busy));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[RAW_W-1:TXC_POS+1] == '0);
  // R9
  line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == |(raw_q & mask_now));
endmodule

// File: rtl/audio_irq_unit.sv
module audio_irq_unit
  import aiu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_underrun_set,
  input  logic              tx_half_empty,
  input  logic              tx_empty,
  input  logic              tx_busy,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              underrun,
  output logic [6:0]        raw_status,
  output logic [DATA_W-1:0] summary_rd,
  output logic              irq
);
  localparam int PAD_W = DATA_W - RAW_W;

  logic             clr_req, mask_wr, ur_d;
  logic [RAW_W-1:0] mask_d, mask_q;

  assign clr_req = host_wr & host_sel & host_wdata[CLR_BIT];
  assign mask_wr = host_wr & ~host_sel;

  aiu_underrun_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(tx_underrun_set), .clr_req(clr_req),
    .flag_d(ur_d), .flag_q(underrun)
  );

  aiu_mask_reg #(.W(RAW_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(host_wdata[RAW_W-1:0]),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  aiu_raw_line u_raw (
    .clk(clk), .rst_n(rst_n), .ur_next(ur_d), .half(tx_half_empty),
    .empty(tx_empty), .busy(tx_busy), .mask_next(mask_d), .mask_now(mask_q),
    .raw_q(raw_status), .irq_q(irq)
  );

  assign summary_rd = {{PAD_W{1'b0}}, raw_status};

  // R4
  ur_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[UR_POS] == underrun);
  // R10
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary_rd[DATA_W-1:RAW_W] == '0 && summary_rd[RAW_W-1:0] == raw_status);
endmodule

// File: tb/audio_irq_unit_test.sv
module audio_irq_unit_test;
  localparam int PERIOD  = 10;
  localparam int DW      = 16;
  localparam int CB      = 2;

  logic clk = 0, rst_n = 0;
  logic ur_set = 0, half = 0, empty = 0, busy = 0, wr = 0, sel = 0;
  logic [DW-1:0] wdata = '0;
  logic underrun, irq;
  logic [6:0] raw;
  logic [DW-1:0] summ;

  int checks = 0, fails = 0;
  logic e_ur = 0;
  logic [6:0] e_mask = '0;

  audio_irq_unit #(.DATA_W(DW), .CLR_BIT(CB)) uut (
    .clk(clk), .rst_n(rst_n), .tx_underrun_set(ur_set), .tx_half_empty(half),
    .tx_empty(empty), .tx_busy(busy), .host_wr(wr), .host_sel(sel),
    .host_wdata(wdata), .underrun(underrun), .raw_status(raw),
    .summary_rd(summ), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [6:0] exp_raw(logic u, logic h, logic e, logic b);
    logic [6:0] v = 7'd0;
    if (u) v = v | 7'b0000001;
    if (h) v = v | 7'b0000010;
    if (e && !b) v = v | 7'b0000100;
    return v;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, update model, check after the edge
  task automatic step(logic s, logic h, logic e, logic b, logic w, logic sl, logic [DW-1:0] d);
    logic [6:0] er;
    @(negedge clk);
    ur_set = s; half = h; empty = e; busy = b; wr = w; sel = sl; wdata = d;
    if (s) e_ur = 1'b1;
    else if (w && sl && d[CB]) e_ur = 1'b0;
    if (w && !sl) e_mask = d[6:0];
    er = exp_raw(e_ur, h, e, b);
    @(posedge clk);
    #(PERIOD/4);
    cmp("R2/R3 underrun", {31'd0, underrun}, {31'd0, e_ur});
    cmp("R4-R7 raw", {25'd0, raw}, {25'd0, er});
    cmp("R8/R9 irq", {31'd0, irq}, {31'd0, |(er & e_mask)});
    cmp("R10 summary", {16'd0, summ}, {25'd0, er});
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R1 reset state
    cmp("R1 irq", {31'd0, irq}, 32'd0);
    cmp("R1 raw", {25'd0, raw}, 32'd0);
    cmp("R1 underrun", {31'd0, underrun}, 32'd0);
    @(negedge clk); rst_n = 1;
    // R1 mask zero: raw sources active, line low
    step(1, 1, 1, 0, 0, 0, '0);
    cmp("R1 mask zero keeps irq low", {31'd0, irq}, 32'd0);
    // R8 mask all ones
    step(0, 1, 1, 0, 1, 0, 16'h007f);
    // R3 clear with clear bit off: no effect
    step(0, 0, 0, 1, 1, 1, 16'h0001);
    cmp("R3 flag kept", {31'd0, underrun}, 32'd1);
    // R3 set and clear same cycle: set wins
    step(1, 0, 0, 1, 1, 1, 16'h0004);
    cmp("R3 set wins", {31'd0, underrun}, 32'd1);
    // R3 proper clear
    step(0, 0, 0, 1, 1, 1, 16'h0004);
    cmp("R3 cleared", {31'd0, underrun}, 32'd0);
    // R6 empty but busy -> no complete bit
    step(0, 0, 1, 1, 0, 0, '0);
    // R9 only complete bit enabled
    step(0, 1, 1, 0, 1, 0, 16'h0004);
    step(0, 1, 1, 1, 0, 0, '0);
    // R8 mask zero drops line
    step(1, 1, 1, 0, 1, 0, 16'hff80);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0] & r[1] & r[2], r[3], r[4], r[5], r[6] & r[7], r[8],
           {r[31:21], r[9] | r[10], r[15:12]});
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule